// File: doc/BRIEF.md
# Split-Register Transfer Frame Counter

This block holds the length of a serial transfer, counted in frames, and tracks how many frames of that transfer have finished. Software sets the length with two register writes. The low half comes from a field inside the control word. The high half comes from a separate upper-length register. The upper register also reads back the full length.

The running count can be reset in two ways. Any write to the control word resets it. A command write with the clear bit set also resets it, and that path leaves the programmed length unchanged. A frame-done pulse advances the count until it reaches the length. At that point the block raises a terminal flag and ignores further pulses. A length of zero means the count never terminates.

The completed count, the frames still remaining and the terminal flag are all visible at the ports.

Top module: `split_frame_counter`

## Requirements
- R1: After reset the length, the completed count, the remaining count and the terminal flag are all zero.
- R2: A control write loads length bits 15:0 from control word bits 23:8 and resets the completed count to zero. The other control word bits and the length high half are not affected.
- R3: An upper-length write loads length bits 31:16 from data bits 31:16. Data bits 15:0 have no effect on the length, and the completed count is kept.
- R4: The full-length readback shows all 32 length bits. The control readback shows length bits 15:0.
- R5: A command write with data bit 4 set resets the completed count and keeps the length. A command write with bit 4 clear changes nothing.
- R6: Each frame-done pulse raises the completed count by one while the block is not terminal.
- R7: The terminal flag is high when the length is nonzero and the completed count is at least the length. A frame-done pulse while terminal leaves the count unchanged.
- R8: With a length of zero the terminal flag stays low, and the completed count advances on every frame-done pulse.
- R9: When a reset of the count (by control write or by clear command) and a frame-done pulse fall in the same cycle, the count becomes zero.
- R10: The remaining count equals the length minus the completed count when the length is nonzero and the block is not terminal. Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data; length low half in bits 23:8 |
| upper_we | input | 1 | Upper-length register write strobe |
| upper_wdata | input | 32 | Upper-length write data; bits 31:16 used |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command data; bit 4 resets the completed count |
| frame_done | input | 1 | One-cycle pulse per finished frame |
| frames_done | output | 32 | Completed frame count |
| frames_left | output | 32 | Frames still remaining |
| at_terminal | output | 1 | Transfer length reached |
| len_rd | output | 32 | Full 32-bit length readback |
| ctrl_len_rd | output | 16 | Length low half as seen in the control word |

## Verification
The bench sweeps every length from 1 to 10 through control writes. For each length it issues two more frame-done pulses than the length, so the exact frame at which the terminal flag rises is checked, along with the hold behaviour after it. The control data also carries set bits outside the length field, and the upper data carries a nonzero low half. These show that only the intended fields reach the length.

Further runs reset the count through each of the two paths, alone and in the same cycle as a frame pulse. This tells the reset priority apart from the increment. A zero-length run shows that the count keeps advancing without ever becoming terminal. A run with the high half set shows that the upper write keeps the count and that the remaining count reflects all 32 bits.

// File: rtl/frmcnt_pkg.sv
package frmcnt_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_STEP  = 2'd2
  } tally_act_e;

  // Reset of the count outranks a frame pulse; pulses stop at terminal.
  function automatic tally_act_e pick_action(input logic clr,
                                             input logic done,
                                             input logic term);
    if (clr)
      return ACT_CLEAR;
    else if (done && !term)
      return ACT_STEP;
    else
      return ACT_HOLD;
  endfunction

endpackage

// File: rtl/frmcnt_len_reg.sv
module frmcnt_len_reg #(
  parameter int CNT_W = 32,
  localparam int HALF = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_we,
  input  logic [HALF-1:0]  lo_val,
  input  logic             hi_we,
  input  logic [HALF-1:0]  hi_val,
  output logic [CNT_W-1:0] len
);

  logic [HALF-1:0] lo_q;
  logic [HALF-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we) lo_q <= lo_val;
      if (hi_we) hi_q <= hi_val;
    end
  end

  assign len = {hi_q, lo_q};

  AST_UPPER_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !lo_we) |=> (len[HALF-1:0] == $past(len[HALF-1:0]))); // R3

  AST_CTRL_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !hi_we) |=> (len[CNT_W-1:HALF] == $past(len[CNT_W-1:HALF]))); // R2

endmodule

// File: rtl/frmcnt_tally.sv
module frmcnt_tally
  import frmcnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             done,
  input  logic             term,
  output logic [CNT_W-1:0] cnt
);

  tally_act_e act;

  assign act = pick_action(clr, done, term);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      unique case (act)
        ACT_CLEAR: cnt <= '0;
        ACT_STEP:  cnt <= cnt + CNT_W'(1);
        default:   cnt <= cnt;
      endcase
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R9

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr && !term) |=> (cnt == $past(cnt) + CNT_W'(1))); // R6

  AST_TERM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !clr) |=> $stable(cnt)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !clr) |=> $stable(cnt)); // R3

endmodule

// File: rtl/frmcnt_status.sv
module frmcnt_status #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] len,
  input  logic [CNT_W-1:0] cnt,
  output logic             term,
  output logic [CNT_W-1:0] left
);

  function automatic logic reached(input logic [CNT_W-1:0] l,
                                   input logic [CNT_W-1:0] c);
    return (l != '0) && (c >= l);
  endfunction

  function automatic logic [CNT_W-1:0] remaining(input logic [CNT_W-1:0] l,
                                                 input logic [CNT_W-1:0] c);
    if (l == '0 || c >= l)
      return '0;
    else
      return l - c;
  endfunction

  assign term = reached(len, cnt);
  assign left = remaining(len, cnt);

  always_comb begin
    AST_ZERO_LEN_OPEN: assert (!(len == '0 && term)); // R8
    AST_LEFT_ZERO_AT_TERM: assert (!(term && left != '0)); // R10
  end

endmodule

// File: rtl/split_frame_counter.sv
module split_frame_counter #(
  parameter int CNT_W     = 32,
  parameter int REG_W     = 32,
  parameter int FIELD_LSB = 8,
  parameter int CLR_BIT   = 4,
  localparam int HALF     = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [REG_W-1:0] ctrl_wdata,
  input  logic             upper_we,
  input  logic [REG_W-1:0] upper_wdata,
  input  logic             cmd_we,
  input  logic [REG_W-1:0] cmd_wdata,
  input  logic             frame_done,
  output logic [CNT_W-1:0] frames_done,
  output logic [CNT_W-1:0] frames_left,
  output logic             at_terminal,
  output logic [CNT_W-1:0] len_rd,
  output logic [HALF-1:0]  ctrl_len_rd
);

  logic             cmd_clr;
  logic             cnt_clr;
  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] cnt;
  logic             term;
  logic [CNT_W-1:0] left;

  assign cmd_clr = cmd_we && cmd_wdata[CLR_BIT];
  assign cnt_clr = ctrl_we || cmd_clr;

  frmcnt_len_reg #(.CNT_W(CNT_W)) u_len (
    .clk    (clk),
    .rst_n  (rst_n),
    .lo_we  (ctrl_we),
    .lo_val (ctrl_wdata[FIELD_LSB +: HALF]),
    .hi_we  (upper_we),
    .hi_val (upper_wdata[REG_W-1 -: HALF]),
    .len    (len)
  );

  frmcnt_status #(.CNT_W(CNT_W)) u_stat (
    .len  (len),
    .cnt  (cnt),
    .term (term),
    .left (left)
  );

  frmcnt_tally #(.CNT_W(CNT_W)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .done  (frame_done),
    .term  (term),
    .cnt   (cnt)
  );

  assign frames_done = cnt;
  assign frames_left = left;
  assign at_terminal = term;
  assign len_rd      = len;
  assign ctrl_len_rd = len[HALF-1:0];

  AST_CMD_KEEPS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !ctrl_we && !upper_we) |=> $stable(len_rd)); // R5

  AST_CTRL_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_len_rd == $past(ctrl_wdata[FIELD_LSB +: HALF]))); // R2

endmodule

// File: tb/split_frame_counter_bench.sv
`timescale 1ns/1ps
module split_frame_counter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, upper_we = 1'b0, cmd_we = 1'b0, frame_done = 1'b0;
  logic [31:0] ctrl_wdata = '0, upper_wdata = '0, cmd_wdata = '0;
  logic [31:0] frames_done, frames_left, len_rd;
  logic        at_terminal;
  logic [15:0] ctrl_len_rd;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_len = '0;
  logic [31:0] m_cnt = '0;

  always #2.5 clk = ~clk;

  split_frame_counter u_split_frame_counter (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .upper_we(upper_we), .upper_wdata(upper_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .frame_done(frame_done),
    .frames_done(frames_done), .frames_left(frames_left),
    .at_terminal(at_terminal), .len_rd(len_rd), .ctrl_len_rd(ctrl_len_rd)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic m_term();
    return (m_len != 0) && (m_cnt >= m_len);
  endfunction

  task automatic check_all(input string req);
    chk(req, "frames_done", frames_done, m_cnt);
    chk(req, "at_terminal", {31'd0, at_terminal}, {31'd0, m_term()});
    chk(req, "frames_left", frames_left, m_term() || m_len == 0 ? 32'd0 : m_len - m_cnt);
    chk(req, "len_rd", len_rd, m_len);
    chk(req, "ctrl_len_rd", {16'd0, ctrl_len_rd}, {16'd0, m_len[15:0]});
  endtask

  // Drive one cycle of stimulus, update the model, sample after the edge.
  task automatic step(input string req,
                      input logic cw, input logic [31:0] cd,
                      input logic uw, input logic [31:0] ud,
                      input logic mw, input logic [31:0] md,
                      input logic fd);
    logic clr;
    @(negedge clk);
    ctrl_we = cw; ctrl_wdata = cd;
    upper_we = uw; upper_wdata = ud;
    cmd_we = mw; cmd_wdata = md;
    frame_done = fd;
    clr = cw || (mw && md[4]);
    if (clr) m_cnt = '0;
    else if (fd && !m_term()) m_cnt = m_cnt + 1;
    if (cw) m_len[15:0] = cd[23:8];
    if (uw) m_len[31:16] = ud[31:16];
    @(negedge clk);
    ctrl_we = 0; upper_we = 0; cmd_we = 0; frame_done = 0;
    check_all(req);
  endtask

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2/R6/R7/R10: length sweep with junk outside the field
    for (int l = 1; l <= 10; l++) begin
      step("R2", 1, 32'hA5000000 | (32'(l) << 8) | 32'h000000FF, 0, 0, 0, 0, 0);
      for (int k = 0; k < l + 2; k++)
        step(k < l ? "R6" : "R7", 0, 0, 0, 0, 0, 0, 1);
    end

    // R3: upper write with nonzero low half, count kept
    step("R3", 0, 0, 1, 32'h0002BEEF, 0, 0, 0);
    chk("R4", "len_rd full", len_rd, 32'h0002000A);
    step("R10", 0, 0, 0, 0, 0, 0, 1);

    // R5: command without clear bit, then with it
    step("R5", 0, 0, 0, 0, 1, 32'hFFFFFFEF, 0);
    step("R5", 0, 0, 0, 0, 1, 32'h00000010, 0);
    chk("R5", "count cleared", frames_done, 32'd0);

    // R9: reset paths colliding with a frame pulse
    step("R6", 0, 0, 0, 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 0, 0, 1);
    step("R9", 0, 0, 0, 0, 1, 32'h00000010, 1);
    step("R6", 0, 0, 0, 0, 0, 0, 1);
    step("R9", 1, 32'h00000300, 0, 0, 0, 0, 1);

    // R8: zero length never terminates
    step("R8", 1, 32'h00000000, 1, 32'h0000FFFF, 0, 0, 0);
    for (int k = 0; k < 40; k++)
      step("R8", 0, 0, 0, 0, 0, 0, 1);

    // R2/R3 together, then count within a high length
    step("R4", 1, 32'h00000500, 1, 32'h00010000, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 1);
    chk("R10", "left high", frames_left, 32'h00010004);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule